// File: doc/BRIEF.md
# Receiver Loss-of-Signal Detector

This block decides whether a line receiver has lost its incoming signal. It runs on the recovered receive clock and watches the received data bit on every cycle. It also watches two analog indications: one says the equalizer gain is at its ceiling, the other says the received power is under the detection threshold. Any of these conditions raises a loss flag, and so does the block's reset.

A long run of zeros also raises the flag. The run is counted on recovered-clock cycles. Once raised, the flag drops only when two things are true together. First, every set cause has gone away. Second, the recent data shows enough marks to be a live signal.

The flag reaches two places. The first is an output pin for systems without a processor, and it shows the live state. The second is a status bit for a host register, at bit 0 of control register 1. This bit stays latched until the host reads it.

Top module: `rx_los_detect`

## Requirements
- R1: While `rst_n` is low, both `los_pin` and `los_stat` are 1, and they rise as soon as `rst_n` falls, without waiting for a clock edge.
- R2: `gain_max_a` passes through a two-flop synchronizer. If it is high ahead of three rising edges of `rclk`, `los_pin` is 1 after the third edge and not before.
- R3: `pwr_low_a` is synchronized the same way and sets `los_pin` with the same three-edge timing.
- R4: A 0 on `rx_bit` at a rising edge adds one to a zero-run count. The count saturates at `ZERO_LIMIT` (default 175). A 1 at an edge returns the count to 0. `los_pin` rises on the edge after the count reaches `ZERO_LIMIT`, which is the edge that samples the (`ZERO_LIMIT`+1)-th consecutive zero.
- R5: `los_pin` falls at an edge only when three things hold before that edge: neither synchronized analog flag is high, the zero-run count is below `ZERO_LIMIT`, and at least `MIN_ONES` (default 4, which is 12.5%) of the last `WIN_LEN` (default 32) sampled bits are 1. Starting from an empty window with the flags low, a steady stream of ones clears the flag on the fifth edge.
- R6: While the window holds fewer than `MIN_ONES` ones, `los_pin` stays 1, even after every set cause has gone.
- R7: `los_pin` always shows the live loss state. It falls without any host action.
- R8: `los_stat` goes to 1 whenever the loss state is set. It returns to 0 only at an edge where `host_rd` is 1 and the loss state is 0 after that edge. A read while loss is active leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rclk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Power-on / reset indication, active low, asynchronous |
| rx_bit | input | 1 | Received data bit, sampled on rising `rclk` |
| gain_max_a | input | 1 | Asynchronous flag: equalizer gain at maximum |
| pwr_low_a | input | 1 | Asynchronous flag: received power below threshold |
| host_rd | input | 1 | Host read strobe for the status bit |
| los_pin | output | 1 | Live loss-of-signal flag for the hardware pin |
| los_stat | output | 1 | Sticky loss-of-signal status bit for the host register |

## Verification
Some properties are checked by assertions on every cycle:
- the zero-run count never exceeds its limit, and a sampled one returns it to zero;
- a synchronized analog flag, or a full zero run, is followed by an active flag;
- the flag falls only when the window held enough ones;
- the status bit is high whenever the flag is high.

Other properties can only be shown by the bench's directed scenarios:
- the exact three-edge latency through the synchronizers;
- the boundary between `ZERO_LIMIT` and `ZERO_LIMIT`+1 zeros;
- a one in the middle of a run restarting the count;
- sparse data that never clears the flag;
- a host read that is refused while loss persists.

// File: rtl/rx_los_detect.sv
module rx_los_detect #(
  parameter int ZERO_LIMIT = 175,
  parameter int WIN_LEN    = 32,
  parameter int MIN_ONES   = 4
) (
  input  logic rclk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic gain_max_a,
  input  logic pwr_low_a,
  input  logic host_rd,
  output logic los_pin,
  output logic los_stat
);

  localparam int ZCW = $clog2(ZERO_LIMIT + 1);
  localparam int WCW = $clog2(WIN_LEN + 1);
  localparam logic [ZCW-1:0] ZLIM_Q = ZCW'(ZERO_LIMIT);
  localparam logic [WCW-1:0] MINO_Q = WCW'(MIN_ONES);

  logic [1:0]         gain_sync, pwr_sync;
  logic [ZCW-1:0]     zero_run;
  logic [WIN_LEN-1:0] win_q;
  logic [WCW-1:0]     ones_cnt;
  logic               los_q, stat_q, los_nxt;
  logic               gain_s, pwr_s, run_hit, dens_ok, set_any;

  assign gain_s   = gain_sync[1];
  assign pwr_s    = pwr_sync[1];
  assign run_hit  = (zero_run == ZLIM_Q);
  assign ones_cnt = WCW'($countones(win_q));
  assign dens_ok  = (ones_cnt >= MINO_Q);
  assign set_any  = gain_s | pwr_s | run_hit;
  assign los_nxt  = set_any | (los_q & ~dens_ok);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      gain_sync <= '0;
      pwr_sync  <= '0;
    end else begin
      gain_sync <= {gain_sync[0], gain_max_a};
      pwr_sync  <= {pwr_sync[0], pwr_low_a};
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)
      zero_run <= '0;
    else if (rx_bit)
      zero_run <= '0;
    else if (!run_hit)
      zero_run <= zero_run + 1'b1;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)
      win_q <= '0;
    else
      win_q <= {win_q[WIN_LEN-2:0], rx_bit};
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      los_q  <= 1'b1;
      stat_q <= 1'b1;
    end else begin
      los_q  <= los_nxt;
      stat_q <= los_nxt | (stat_q & ~host_rd);
    end
  end

  assign los_pin  = los_q;
  assign los_stat = stat_q;

  AST_RUN_SATURATES: assert property (@(posedge rclk) disable iff (!rst_n)
    zero_run <= ZLIM_Q); // R4
  AST_ONE_RESTARTS: assert property (@(posedge rclk) disable iff (!rst_n)
    rx_bit |=> (zero_run == '0)); // R4
  AST_RUN_SETS: assert property (@(posedge rclk) disable iff (!rst_n)
    (zero_run == ZLIM_Q) |=> los_q); // R4
  AST_GAIN_SETS: assert property (@(posedge rclk) disable iff (!rst_n)
    gain_sync[1] |=> los_q); // R2
  AST_PWR_SETS: assert property (@(posedge rclk) disable iff (!rst_n)
    pwr_sync[1] |=> los_q); // R3
  AST_CLEAR_NEEDS_MARKS: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(los_q) |-> ($past(ones_cnt) >= MINO_Q)); // R5
  AST_STAT_COVERS_PIN: assert property (@(posedge rclk) disable iff (!rst_n)
    los_q |-> stat_q); // R8

endmodule

// File: tb/rx_los_detect_tb.sv
module rx_los_detect_tb_top;
  logic rclk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0;
  logic gain_max_a = 1'b0;
  logic pwr_low_a = 1'b0;
  logic host_rd = 1'b0;
  logic los_pin, los_stat;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 rclk = ~rclk;

  rx_los_detect dut_i (
    .rclk(rclk), .rst_n(rst_n), .rx_bit(rx_bit),
    .gain_max_a(gain_max_a), .pwr_low_a(pwr_low_a),
    .host_rd(host_rd), .los_pin(los_pin), .los_stat(los_stat)
  );

  task automatic step(input int n);
    repeat (n) @(posedge rclk);
    @(negedge rclk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #5;
    chk("R1 pin in reset", los_pin, 1'b1);
    chk("R1 stat in reset", los_stat, 1'b1);
    @(negedge rclk);
    rst_n = 1'b1;
  endtask

  task automatic t_first_clear;
    rx_bit = 1'b1;
    step(4);
    chk("R5 held after four ones", los_pin, 1'b1);
    step(1);
    chk("R5 cleared on fifth edge", los_pin, 1'b0);
    chk("R8 stat still latched", los_stat, 1'b1);
    host_rd = 1'b1; step(1); host_rd = 1'b0;
    chk("R8 stat cleared by read", los_stat, 1'b0);
  endtask

  task automatic t_zero_run;
    rx_bit = 1'b0;
    step(175);
    chk("R4 no loss at limit", los_pin, 1'b0);
    step(1);
    chk("R4 loss after limit+1 zeros", los_pin, 1'b1);
    chk("R8 stat set by zero run", los_stat, 1'b1);
    step(20);
    chk("R4 loss held in long run", los_pin, 1'b1);
    rx_bit = 1'b1;
    step(4);
    chk("R5 held after four ones", los_pin, 1'b1);
    step(1);
    chk("R7 pin clears without host", los_pin, 1'b0);
    host_rd = 1'b1; step(1); host_rd = 1'b0;
  endtask

  task automatic t_run_restart;
    rx_bit = 1'b0; step(170);
    rx_bit = 1'b1; step(1);
    rx_bit = 1'b0; step(175);
    chk("R4 one restarted count", los_pin, 1'b0);
    step(1);
    chk("R4 loss after restarted run", los_pin, 1'b1);
    rx_bit = 1'b1; step(5);
    chk("R5 recovered", los_pin, 1'b0);
    host_rd = 1'b1; step(1); host_rd = 1'b0;
  endtask

  task automatic t_flag(input bit use_gain, input string req);
    if (use_gain) gain_max_a = 1'b1; else pwr_low_a = 1'b1;
    step(2);
    chk({req, " not yet after two edges"}, los_pin, 1'b0);
    step(1);
    chk({req, " set on third edge"}, los_pin, 1'b1);
    step(10);
    chk({req, " held despite ones"}, los_pin, 1'b1);
    host_rd = 1'b1; step(1); host_rd = 1'b0;
    chk("R8 read refused while active", los_stat, 1'b1);
    if (use_gain) gain_max_a = 1'b0; else pwr_low_a = 1'b0;
    step(2);
    chk({req, " held during sync drain"}, los_pin, 1'b1);
    step(1);
    chk("R5 cleared after flag drops", los_pin, 1'b0);
    host_rd = 1'b1; step(1); host_rd = 1'b0;
  endtask

  task automatic t_sparse;
    gain_max_a = 1'b1;
    rx_bit = 1'b0;
    step(40);
    gain_max_a = 1'b0;
    for (int i = 0; i < 64; i++) begin
      rx_bit = (i % 16 == 0);
      step(1);
    end
    chk("R6 sparse ones keep loss", los_pin, 1'b1);
    rx_bit = 1'b1; step(5);
    chk("R5 dense ones clear", los_pin, 1'b0);
  endtask

  task automatic t_mid_reset;
    rst_n = 1'b0;
    #1;
    chk("R1 async pin", los_pin, 1'b1);
    chk("R1 async stat", los_stat, 1'b1);
    @(negedge rclk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_first_clear();
    t_zero_run();
    t_run_restart();
    t_flag(1'b1, "R2");
    t_flag(1'b0, "R3");
    t_sparse();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule